// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Level and Character Timeout

This block sits between a serial receiver and the host side of a UART. Each character the receiver assembles is pushed together with its parity, framing and break flags. The host removes characters one at a time with a pop pulse. With buffering enabled the block holds up to sixteen characters. With buffering disabled it acts as a single holding register. A write to the FIFO control register turns buffering on or off, picks the trigger threshold, and can flush the stored characters.

The block drives the receive-side line status bits: data ready, overrun, parity, framing and break, and error-in-buffer. It also raises two requests. The first is a data-available request when the fill level reaches the selected threshold. The second is a character-timeout request when characters sit unread and neither side has touched the buffer for four character times. Idle time is counted in 16x baud ticks, and the character length in bits is an input.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, buffering is disabled, the level is 0, every line status bit is 0 and all requests are low. Capacity is DEPTH (16) characters with buffering enabled and 1 character with it disabled.
- R2: On an FCR write, bit 0 becomes the buffering enable and bits 7:6 become the trigger select. The buffer is emptied when bit 1 is 1 or when bit 0 differs from the current enable. Bit 2 (transmit-side clear) has no effect on this block. A clearing write discards any push or pop in the same cycle.
- R3: A push while the buffer is at capacity is discarded and sets overrun (lsr bit 1). This holds even when a pop happens in the same cycle.
- R4: lsr bit 0 is 1 while at least one character is stored. head_data_o shows the oldest character, or 0 when the buffer is empty. A pop from an empty buffer has no effect.
- R5: Characters leave in arrival order. A push and a pop in the same cycle on a non-full, non-empty buffer leave the level unchanged.
- R6: An accepted push carrying a parity, framing or break flag sets lsr bit 2, 3 or 4 respectively. An lsr_rd_i pulse clears bits 1 to 4, but a set in the same cycle wins. lsi_o is high while any of bits 1 to 4 is set.
- R7: lsr bit 7 is 1 exactly while at least one stored character carries an error flag. lsr bits 6:5 are always 0.
- R8: With buffering enabled, trig_o is high when the level is at least 1, 4, 8 or 14 for trigger select 00, 01, 10 or 11. With buffering disabled, trig_o equals data ready.
- R9: An idle counter advances once per tick16_i pulse. It restarts on an accepted push, an effective pop, a clear, or while the buffer is empty. timeout_o is high when buffering is enabled, the buffer is non-empty and the counter has reached 64 × char_bits_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Receiver delivers a character |
| push_data_i | input | 8 | Received character |
| push_perr_i | input | 1 | Parity error flag of the character |
| push_ferr_i | input | 1 | Framing error flag of the character |
| push_brk_i | input | 1 | Break flag of the character |
| pop_i | input | 1 | Host removes the head character |
| fcr_wr_i | input | 1 | FIFO control register write strobe |
| fcr_data_i | input | 8 | FIFO control register write data |
| lsr_rd_i | input | 1 | Host reads the line status register |
| tick16_i | input | 1 | 16x baud tick |
| char_bits_i | input | 4 | Character length in bit times |
| head_data_o | output | 8 | Oldest stored character, 0 when empty |
| level_o | output | 5 | Number of stored characters |
| fifo_en_o | output | 1 | Buffering enabled |
| lsr_o | output | 8 | Receive-side line status bits |
| lsi_o | output | 1 | Line status request |
| trig_o | output | 1 | Data-available request |
| timeout_o | output | 1 | Character timeout request |

## Verification
All state changes at the clock edge that samples the stimulus. Level, head byte, status bits and both requests therefore show the new value one edge after the inputs are applied, with no further pipeline delay. The bench drives inputs just after a rising edge. Its queue-based model advances at that same rising edge, and every output is compared at the following falling edge. The timeout is compared on the same cycle basis, so it rises exactly on the cycle the idle tick count meets 64 × char_bits_i.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int TW    = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [7:0]                   push_data_i,
  input  logic                         push_perr_i,
  input  logic                         push_ferr_i,
  input  logic                         push_brk_i,
  input  logic                         pop_i,
  input  logic                         fcr_wr_i,
  input  logic [7:0]                   fcr_data_i,
  input  logic                         lsr_rd_i,
  input  logic                         tick16_i,
  input  logic [3:0]                   char_bits_i,
  output logic [7:0]                   head_data_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         fifo_en_o,
  output logic [7:0]                   lsr_o,
  output logic                         lsi_o,
  output logic                         trig_o,
  output logic                         timeout_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, err_cnt, tlev;
  logic [1:0]    tsel;
  logic          en, oe, pe, fe, bi;
  logic [TW-1:0] idle;

  wire           clr      = fcr_wr_i && (fcr_data_i[1] || (fcr_data_i[0] != en));
  wire [CW-1:0]  cap      = en ? CW'(DEPTH) : CW'(1);
  wire           has      = (count != '0);
  wire           do_push  = push_i && !clr && (count < cap);
  wire           drop     = push_i && !clr && (count >= cap);
  wire           do_pop   = pop_i && has && !clr;
  wire [10:0]    head     = mem[rd_ptr];
  wire           push_err = push_perr_i | push_ferr_i | push_brk_i;
  wire           pop_err  = |head[10:8];
  wire [TW-1:0]  tlim     = TW'({char_bits_i, 6'd0});

  logic unused_fcr;
  assign unused_fcr = ^fcr_data_i[5:2];

  always_comb begin
    case (tsel)
      2'b00:   tlev = CW'(1);
      2'b01:   tlev = CW'(DEPTH/4);
      2'b10:   tlev = CW'(DEPTH/2);
      default: tlev = CW'(DEPTH-2);
    endcase
  end

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {push_brk_i, push_ferr_i, push_perr_i, push_data_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
      en      <= 1'b0;
      tsel    <= 2'b00;
      idle    <= '0;
    end else begin
      if (fcr_wr_i) begin
        en   <= fcr_data_i[0];
        tsel <= fcr_data_i[7:6];
      end
      if (clr) begin
        rd_ptr  <= '0;
        wr_ptr  <= '0;
        count   <= '0;
        err_cnt <= '0;
      end else begin
        if (do_push) wr_ptr <= nxt(wr_ptr);
        if (do_pop)  rd_ptr <= nxt(rd_ptr);
        count   <= count + CW'(do_push) - CW'(do_pop);
        err_cnt <= err_cnt + CW'(do_push && push_err) - CW'(do_pop && pop_err);
      end
      if (clr || do_push || do_pop || !has) idle <= '0;
      else if (tick16_i && idle != '1)       idle <= idle + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0;
    end else begin
      oe <= drop                     | (oe & ~lsr_rd_i);
      pe <= (do_push & push_perr_i)  | (pe & ~lsr_rd_i);
      fe <= (do_push & push_ferr_i)  | (fe & ~lsr_rd_i);
      bi <= (do_push & push_brk_i)   | (bi & ~lsr_rd_i);
    end
  end

  assign head_data_o = has ? head[7:0] : 8'h00;
  assign level_o     = count;
  assign fifo_en_o   = en;
  assign lsr_o       = {err_cnt != '0, 2'b00, bi, fe, pe, oe, has};
  assign lsi_o       = oe | pe | fe | bi;
  assign trig_o      = en ? (count >= tlev) : has;
  assign timeout_o   = en && has && (idle >= tlim);
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       push_i,
  input logic                       pop_i,
  input logic                       fcr_wr_i,
  input logic [7:0]                 fcr_data_i,
  input logic [$clog2(DEPTH+1)-1:0] level_o,
  input logic                       fifo_en_o,
  input logic [7:0]                 lsr_o,
  input logic [7:0]                 head_data_o,
  input logic                       trig_o,
  input logic                       timeout_o
);
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o <= DEPTH) && (fifo_en_o || level_o <= 1));

  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr_i && fcr_data_i[1]) |=> (level_o == 0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !fcr_wr_i && fifo_en_o && level_o == DEPTH)
    |=> (lsr_o[1] && level_o == DEPTH));

  assert_empty_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == 0) |-> (head_data_o == 8'h00 && !lsr_o[7]));

  assert_pushpop_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !fcr_wr_i && fifo_en_o && level_o != 0 && level_o < DEPTH)
    |=> $stable(level_o));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_o[6:5] == 2'b00);

  assert_trig_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_o && level_o >= DEPTH-2) |-> trig_o);

  assert_timeout_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (fifo_en_o && level_o != 0));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
  .fcr_wr_i(fcr_wr_i), .fcr_data_i(fcr_data_i), .level_o(level_o),
  .fifo_en_o(fifo_en_o), .lsr_o(lsr_o), .head_data_o(head_data_o),
  .trig_o(trig_o), .timeout_o(timeout_o)
);

// File: tb/uart_rx_fifo_tb_top.sv
module uart_rx_fifo_tb_top;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;

  logic clk = 0, rst_n = 0;
  logic push = 0, perr = 0, ferr = 0, brk = 0, pop = 0, fwr = 0, lrd = 0, tick = 0;
  logic [7:0] pdata = 0, fdata = 0;
  logic [3:0] cbits = 4'd10;
  logic [7:0] head, lsr;
  logic [4:0] level;
  logic fen, lsi, trig, tmo;

  int compared = 0, mismatched = 0;
  bit done = 0;

  uart_rx_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(pdata),
    .push_perr_i(perr), .push_ferr_i(ferr), .push_brk_i(brk), .pop_i(pop),
    .fcr_wr_i(fwr), .fcr_data_i(fdata), .lsr_rd_i(lrd), .tick16_i(tick),
    .char_bits_i(cbits), .head_data_o(head), .level_o(level), .fifo_en_o(fen),
    .lsr_o(lsr), .lsi_o(lsi), .trig_o(trig), .timeout_o(tmo)
  );

  always #(PERIOD/2) clk = ~clk;

  logic [10:0] q[$];
  bit m_en, m_oe, m_pe, m_fe, m_bi;
  logic [1:0] m_ts;
  int idle;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_en = 0; m_ts = 0; idle = 0;
      m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
    end else begin
      bit clr, acc, drp, pd;
      int cap;
      clr = fwr && (fdata[1] || (fdata[0] != m_en));
      cap = m_en ? DEPTH : 1;
      acc = push && !clr && q.size() < cap;
      drp = push && !clr && q.size() >= cap;
      pd  = pop && !clr && q.size() > 0;
      if (clr || acc || pd || q.size() == 0) idle = 0;
      else if (tick && idle < 1023) idle++;
      if (pd) void'(q.pop_front());
      if (acc) q.push_back({brk, ferr, perr, pdata});
      if (clr) q.delete();
      m_oe = drp | (m_oe & !lrd);
      m_pe = (acc & perr) | (m_pe & !lrd);
      m_fe = (acc & ferr) | (m_fe & !lrd);
      m_bi = (acc & brk) | (m_bi & !lrd);
      if (fwr) begin m_en = fdata[0]; m_ts = fdata[7:6]; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int n, tl;
      bit e7;
      n = q.size();
      e7 = 0;
      foreach (q[i]) if (q[i][10:8] != 0) e7 = 1;
      tl = (m_ts == 0) ? 1 : (m_ts == 1) ? 4 : (m_ts == 2) ? 8 : 14;
      chk("R1 level", level, n);
      chk("R2 enable", fen, m_en);
      chk("R4 head", head, n ? q[0][7:0] : 0);
      chk("R4 ready", lsr[0], n > 0);
      chk("R3 overrun", lsr[1], m_oe);
      chk("R6 errbits", lsr[4:2], {m_bi, m_fe, m_pe});
      chk("R6 lsi", lsi, m_oe | m_pe | m_fe | m_bi);
      chk("R7 errfifo", {lsr[7], lsr[6:5]}, {e7, 2'b00});
      chk("R8 trig", trig, m_en ? (n >= tl) : (n > 0));
      chk("R9 timeout", tmo, m_en && n > 0 && idle >= cbits * 64);
    end
  end

  task automatic idle_in();
    push = 0; pop = 0; fwr = 0; lrd = 0; perr = 0; ferr = 0; brk = 0; tick = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle_in();
  endtask

  task automatic do_push(logic [7:0] d, logic p = 0, logic f = 0, logic b = 0);
    push = 1; pdata = d; perr = p; ferr = f; brk = b; step();
  endtask

  task automatic do_pop(); pop = 1; step(); endtask
  task automatic do_fcr(logic [7:0] v); fwr = 1; fdata = v; step(); endtask
  task automatic do_lsr(); lrd = 1; step(); endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    chk("R1 reset level", level, 0);
    chk("R1 reset lsr", lsr, 0);
    // non-buffered mode: single holding register
    do_push(8'hA5);
    do_push(8'h5A);
    chk("R3 single overrun", lsr[1], 1);
    chk("R1 single cap head", head, 8'hA5);
    do_lsr();
    chk("R6 lsr read clears", lsr[1], 0);
    do_pop();
    do_pop();
    chk("R4 empty pop", level, 0);
    // enable buffering (clears)
    do_fcr(8'h01);
    for (int i = 0; i < 18; i++) do_push(8'(i + 16), i == 3, i == 5, i == 7);
    chk("R3 full level", level, DEPTH);
    chk("R7 errfifo set", lsr[7], 1);
    push = 1; pop = 1; pdata = 8'hEE; step();
    chk("R3 full push with pop dropped", level, DEPTH - 1);
    push = 1; pop = 1; pdata = 8'hEF; step();
    chk("R5 push pop level", level, DEPTH - 1);
    do_fcr(8'h05);
    chk("R2 tx clear no effect", level, DEPTH - 1);
    for (int s = 1; s < 4; s++) begin
      do_fcr({2'(s), 6'b000001});
      for (int k = 0; k < 4; k++) do_pop();
    end
    do_fcr(8'hC1);
    for (int k = 0; k < 8; k++) do_pop();
    chk("R7 errfifo cleared", lsr[7], 0);
    push = 1; pdata = 8'h77; fwr = 1; fdata = 8'h03; step();
    chk("R2 clear beats push", level, 0);
    // timeout
    cbits = 4'd2;
    do_push(8'h42);
    for (int k = 0; k < 130; k++) begin tick = 1; step(); end
    chk("R9 timeout raised", tmo, 1);
    do_pop();
    chk("R9 timeout gone", tmo, 0);
    // random mix in buffered mode
    for (int k = 0; k < 3000; k++) begin
      push = ($urandom_range(0, 2) != 0); pdata = 8'($urandom);
      perr = ($urandom_range(0, 9) == 0); ferr = ($urandom_range(0, 9) == 0);
      brk = ($urandom_range(0, 15) == 0);
      pop = ($urandom_range(0, 2) == 0); lrd = ($urandom_range(0, 7) == 0);
      tick = ($urandom_range(0, 1) == 0);
      fwr = ($urandom_range(0, 60) == 0); fdata = {2'($urandom), 4'b0000, 1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 7) != 0)};
      if (k > 1500) pop = ($urandom_range(0, 9) == 0);
      step();
    end
    do_fcr(8'h00);
    chk("R2 disable clears", level, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule